// File: doc/BRIEF.md
# E3 Line Alarm Monitor

This block watches a recovered E3 serial bit stream and raises or drops four line alarms: loss of signal, loss of frame, alarm indication signal and remote alarm indication. It sits behind a framer. The framer supplies a bit-valid strobe with each recovered data bit, a start-of-frame pulse, and a once-per-frame verdict on the frame alignment word. Each alarm has its own declare rule and its own, separate, clear rule. Some rules count frames and others count bits, so each alarm has hysteresis that does not depend on the other alarms.

Each alarm drives a level flag and a one-cycle change pulse. The change pulse lets downstream logic catch every transition without keeping an edge detector of its own. A mode input selects bipolar or unipolar line operation. Loss of signal has no meaning on a unipolar line, so it is forced off in that mode.

Top module: `e3_alarm_mon`

## Requirements
- R1: While `rst` is high and after it is released, `alarm[0]` (LOS), `alarm[2]` (AIS) and `alarm[3]` (RAI) are 0, `alarm[1]` (LOF) is 1, and all `alarm_chg` bits are 0.
- R2: In bipolar mode (`mode_bip`=1), LOS becomes 1 on the clock edge that accepts the 192nd consecutive valid zero bit. With 191 zeros it stays 0. Cycles with `bit_vld`=0 neither count nor break the run.
- R3: A set LOS clears only after a window of 192 valid bits shows no run of four or more zeros. The window begins with the first valid one. When a run reaches four zeros, the window is abandoned and a new window starts at the next one. LOS clears on the edge that accepts the 192nd bit of the window.
- R4: When `mode_bip`=0, LOS is 0 from the next edge onward and its counters are cleared. After bipolar mode is selected again, the count of 192 zeros starts over.
- R5: Frames are paired, starting with the first `sof` after reset. At the `sof` that closes each pair, AIS is set if the two frames held four or fewer zero bits in total, and cleared if they held five or more. AIS changes at no other time.
- R6: The framing verdict is a `fas_vld` strobe, with `fas_ok`=1 meaning the frame alignment word is good. LOF sets after four consecutive bad verdicts and clears after three consecutive good verdicts. A verdict of the other kind restarts the count.
- R7: Bit 11 of each frame is sampled. Bit 1 is the first valid bit after `sof`. RAI sets after four consecutive frames with that bit equal to 1, and clears after four consecutive frames with it equal to 0.
- R8: `alarm_chg[i]` is 1 for exactly the one cycle in which `alarm[i]` first shows a new value. The bit order is 0 LOS, 1 LOF, 2 AIS, 3 RAI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_bip | input | 1 | 1 = bipolar line (LOS enabled), 0 = unipolar |
| bit_vld | input | 1 | Qualifies `bit_dat` this cycle |
| bit_dat | input | 1 | Recovered data bit |
| sof | input | 1 | Start-of-frame pulse; the next valid bit is bit 1 |
| fas_vld | input | 1 | Per-frame alignment verdict strobe |
| fas_ok | input | 1 | 1 = alignment word good, 0 = bad |
| alarm | output | 4 | Alarm levels: 0 LOS, 1 LOF, 2 AIS, 3 RAI |
| alarm_chg | output | 4 | One-cycle pulse when the matching alarm changes |

## Verification
The assertions rely on three properties of the inputs:
- `sof` arrives in a cycle without `bit_vld`, so that each bit belongs to exactly one frame.
- `fas_vld` is a single-cycle strobe, once per frame.
- Any transition of an alarm can be traced back to the stimulus one edge earlier.

The stimulus keeps within these properties. It places every `sof` and every verdict strobe in idle cycles of their own, between blocks of exactly 1536 data bits. It changes `mode_bip` only in idle cycles, so a mode switch never coincides with a bit.

// File: rtl/e3am_pkg.sv
package e3am_pkg;

    localparam int E3_FRAME_BITS   = 1536;
    localparam int LOS_ZERO_LIMIT  = 192;
    localparam int LOS_WINDOW_BITS = 192;
    localparam int LOS_EXZ_RUN     = 4;
    localparam int AIS_MAX_ZEROS   = 4;
    localparam int RAI_BIT_POS     = 11;
    localparam int RAI_SET_FRAMES  = 4;
    localparam int RAI_CLR_FRAMES  = 4;
    localparam int LOF_SET_FRAMES  = 4;
    localparam int LOF_CLR_FRAMES  = 3;

    typedef enum logic [1:0] {
        IDX_LOS = 2'd0,
        IDX_LOF = 2'd1,
        IDX_AIS = 2'd2,
        IDX_RAI = 2'd3
    } alm_idx_e;

    typedef struct packed {
        logic vld;
        logic dat;
    } line_bit_t;

    typedef struct packed {
        logic act;
        logic chg;
    } alm_state_t;

    // Width of a counter that must hold values 0..maxv.
    function automatic int cnt_w(input int maxv);
        return (maxv < 2) ? 1 : $clog2(maxv + 1);
    endfunction

endpackage

// File: rtl/e3am_hyst.sv
// Frame-event alarm with separate consecutive-count set and clear thresholds.
module e3am_hyst
    import e3am_pkg::*;
#(
    parameter int   SET_N   = 4,
    parameter int   CLR_N   = 4,
    parameter logic RST_VAL = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       evt_vld,
    input  logic       evt_set,
    output alm_state_t st_o
);
    localparam int SW = cnt_w(SET_N);
    localparam int CW = cnt_w(CLR_N);
    localparam logic [SW-1:0] S_LIM = SW'(SET_N);
    localparam logic [CW-1:0] C_LIM = CW'(CLR_N);

    logic [SW-1:0] set_run_q, set_run_d;
    logic [CW-1:0] clr_run_q, clr_run_d;
    logic          flag_q, flag_d, chg_q, past_ok;

    always_comb begin
        set_run_d = set_run_q;
        clr_run_d = clr_run_q;
        flag_d    = flag_q;
        if (evt_vld) begin
            if (evt_set) begin
                clr_run_d = '0;
                if (set_run_q != S_LIM) set_run_d = set_run_q + 1'b1;
                if (set_run_d == S_LIM) flag_d = 1'b1;
            end else begin
                set_run_d = '0;
                if (clr_run_q != C_LIM) clr_run_d = clr_run_q + 1'b1;
                if (clr_run_d == C_LIM) flag_d = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            set_run_q <= '0;
            clr_run_q <= '0;
            flag_q    <= RST_VAL;
            chg_q     <= 1'b0;
            past_ok   <= 1'b0;
        end else begin
            set_run_q <= set_run_d;
            clr_run_q <= clr_run_d;
            flag_q    <= flag_d;
            chg_q     <= flag_d ^ flag_q;
            past_ok   <= 1'b1;
        end
    end

    assign st_o = '{act: flag_q, chg: chg_q};

    assert_hyst_rise_cause_R6_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(flag_q)) |-> $past(evt_vld && evt_set));
    assert_hyst_fall_cause_R6_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(flag_q)) |-> $past(evt_vld && !evt_set));
    assert_hyst_chg_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (chg_q == (flag_q != $past(flag_q))));
endmodule

// File: rtl/e3am_los.sv
// Loss-of-signal detector: zero-run declare, clean-window clear.
module e3am_los
    import e3am_pkg::*;
#(
    parameter int ZERO_LIMIT = 192,
    parameter int WIN_BITS   = 192,
    parameter int EXZ_RUN    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_bip,
    input  line_bit_t  bit_i,
    output alm_state_t st_o
);
    localparam int ZW = cnt_w(ZERO_LIMIT);
    localparam int WW = cnt_w(WIN_BITS);
    localparam int RW = cnt_w(EXZ_RUN);
    localparam logic [ZW-1:0] Z_LIM = ZW'(ZERO_LIMIT);
    localparam logic [WW-1:0] W_LIM = WW'(WIN_BITS);
    localparam logic [RW-1:0] R_LIM = RW'(EXZ_RUN);

    logic [ZW-1:0] zrun_q, zrun_d;
    logic [WW-1:0] wcnt_q, wcnt_d;
    logic [RW-1:0] wrun_q, wrun_d;
    logic          win_q, win_d;
    logic          los_q, los_d, chg_q, past_ok;

    always_comb begin
        zrun_d = zrun_q;
        wcnt_d = wcnt_q;
        wrun_d = wrun_q;
        win_d  = win_q;
        los_d  = los_q;
        if (!mode_bip) begin
            zrun_d = '0;
            wcnt_d = '0;
            wrun_d = '0;
            win_d  = 1'b0;
            los_d  = 1'b0;
        end else if (bit_i.vld) begin
            if (!los_q) begin
                // declare path: count consecutive zeros
                if (bit_i.dat)            zrun_d = '0;
                else if (zrun_q != Z_LIM) zrun_d = zrun_q + 1'b1;
                if (!bit_i.dat && zrun_d == Z_LIM) begin
                    los_d = 1'b1;
                    win_d = 1'b0;
                end
            end else if (!win_q) begin
                // waiting for the one that opens a clear window
                if (bit_i.dat) begin
                    win_d  = 1'b1;
                    wcnt_d = WW'(1);
                    wrun_d = '0;
                end
            end else begin
                wcnt_d = wcnt_q + 1'b1;
                if (bit_i.dat)            wrun_d = '0;
                else if (wrun_q != R_LIM) wrun_d = wrun_q + 1'b1;
                if (wrun_d == R_LIM) begin
                    win_d = 1'b0;
                end else if (wcnt_d == W_LIM) begin
                    los_d  = 1'b0;
                    win_d  = 1'b0;
                    zrun_d = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zrun_q  <= '0;
            wcnt_q  <= '0;
            wrun_q  <= '0;
            win_q   <= 1'b0;
            los_q   <= 1'b0;
            chg_q   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            zrun_q  <= zrun_d;
            wcnt_q  <= wcnt_d;
            wrun_q  <= wrun_d;
            win_q   <= win_d;
            los_q   <= los_d;
            chg_q   <= los_d ^ los_q;
            past_ok <= 1'b1;
        end
    end

    assign st_o = '{act: los_q, chg: chg_q};

    assert_los_unipolar_off_R4: assert property (@(posedge clk) disable iff (rst)
        !mode_bip |=> !los_q);
    assert_los_rise_on_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $rose(los_q)) |-> $past(mode_bip && bit_i.vld && !bit_i.dat));
    assert_los_fall_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $fell(los_q)) |-> $past(!mode_bip || bit_i.vld));
    assert_los_chg_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (chg_q == (los_q != $past(los_q))));
endmodule

// File: rtl/e3am_ais.sv
// All-ones detector evaluated over aligned pairs of frames.
module e3am_ais
    import e3am_pkg::*;
#(
    parameter int MAX_ZEROS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  line_bit_t  bit_i,
    output alm_state_t st_o
);
    localparam int ZSAT_V = MAX_ZEROS + 1;
    localparam int ZW     = cnt_w(ZSAT_V);
    localparam logic [ZW-1:0] Z_SAT = ZW'(ZSAT_V);
    localparam logic [ZW-1:0] Z_MAX = ZW'(MAX_ZEROS);

    logic [ZW-1:0] zc_q, zc_d;
    logic          seen_q, seen_d, ph_q, ph_d;
    logic          ais_q, ais_d, chg_q, past_ok;

    always_comb begin
        zc_d   = zc_q;
        seen_d = seen_q;
        ph_d   = ph_q;
        ais_d  = ais_q;
        if (sof) begin
            if (!seen_q) begin
                seen_d = 1'b1;
                ph_d   = 1'b0;
                zc_d   = '0;
            end else if (!ph_q) begin
                ph_d = 1'b1;
            end else begin
                ais_d = (zc_q <= Z_MAX);
                ph_d  = 1'b0;
                zc_d  = '0;
            end
        end else if (seen_q && bit_i.vld && !bit_i.dat && zc_q != Z_SAT) begin
            zc_d = zc_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            zc_q    <= '0;
            seen_q  <= 1'b0;
            ph_q    <= 1'b0;
            ais_q   <= 1'b0;
            chg_q   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            zc_q    <= zc_d;
            seen_q  <= seen_d;
            ph_q    <= ph_d;
            ais_q   <= ais_d;
            chg_q   <= ais_d ^ ais_q;
            past_ok <= 1'b1;
        end
    end

    assign st_o = '{act: ais_q, chg: chg_q};

    assert_ais_only_at_sof_R5: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$stable(ais_q)) |-> $past(sof));
    assert_ais_chg_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (chg_q == (ais_q != $past(ais_q))));
endmodule

// File: rtl/e3am_bitpos.sv
// Bit position counter from start of frame; emits the sample of one chosen bit.
module e3am_bitpos
    import e3am_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int SAMPLE_POS = 11
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sof,
    input  line_bit_t bit_i,
    output logic      smp_vld,
    output logic      smp_dat
);
    localparam int PW = cnt_w(FRAME_BITS);
    localparam logic [PW-1:0] P_MAX = PW'(FRAME_BITS);
    localparam logic [PW-1:0] P_SMP = PW'(SAMPLE_POS);

    logic [PW-1:0] pos_q;
    logic [PW-1:0] pos_inc;
    logic          seen_q;

    assign pos_inc = (pos_q == P_MAX) ? pos_q : pos_q + 1'b1;
    assign smp_vld = seen_q && !sof && bit_i.vld && (pos_inc == P_SMP) && (pos_q != P_MAX);
    assign smp_dat = bit_i.dat;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            seen_q <= 1'b0;
        end else if (sof) begin
            pos_q  <= '0;
            seen_q <= 1'b1;
        end else if (seen_q && bit_i.vld) begin
            pos_q  <= pos_inc;
        end
    end

    assert_bitpos_sample_on_bit_R7: assert property (@(posedge clk) disable iff (rst)
        smp_vld |-> (bit_i.vld && !sof));
endmodule

// File: rtl/e3_alarm_mon.sv
module e3_alarm_mon
    import e3am_pkg::*;
#(
    parameter int FRAME_BITS = E3_FRAME_BITS,
    parameter int LOS_ZEROS  = LOS_ZERO_LIMIT,
    parameter int LOS_WIN    = LOS_WINDOW_BITS,
    parameter int EXZ_RUN    = LOS_EXZ_RUN,
    parameter int AIS_ZEROS  = AIS_MAX_ZEROS,
    parameter int RAI_POS    = RAI_BIT_POS,
    parameter int RAI_SET    = RAI_SET_FRAMES,
    parameter int RAI_CLR    = RAI_CLR_FRAMES,
    parameter int LOF_SET    = LOF_SET_FRAMES,
    parameter int LOF_CLR    = LOF_CLR_FRAMES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_bip,
    input  logic       bit_vld,
    input  logic       bit_dat,
    input  logic       sof,
    input  logic       fas_vld,
    input  logic       fas_ok,
    output logic [3:0] alarm,
    output logic [3:0] alarm_chg
);
    line_bit_t  lbit;
    alm_state_t st_los, st_lof, st_ais, st_rai;
    logic       rai_vld, rai_dat;

    assign lbit = '{vld: bit_vld, dat: bit_dat};

    e3am_los #(.ZERO_LIMIT(LOS_ZEROS), .WIN_BITS(LOS_WIN), .EXZ_RUN(EXZ_RUN)) u_los (
        .clk(clk), .rst(rst), .mode_bip(mode_bip), .bit_i(lbit), .st_o(st_los));

    e3am_ais #(.MAX_ZEROS(AIS_ZEROS)) u_ais (
        .clk(clk), .rst(rst), .sof(sof), .bit_i(lbit), .st_o(st_ais));

    e3am_bitpos #(.FRAME_BITS(FRAME_BITS), .SAMPLE_POS(RAI_POS)) u_pos (
        .clk(clk), .rst(rst), .sof(sof), .bit_i(lbit),
        .smp_vld(rai_vld), .smp_dat(rai_dat));

    e3am_hyst #(.SET_N(RAI_SET), .CLR_N(RAI_CLR), .RST_VAL(1'b0)) u_rai (
        .clk(clk), .rst(rst), .evt_vld(rai_vld), .evt_set(rai_dat), .st_o(st_rai));

    // a bad alignment verdict pushes toward loss of frame
    e3am_hyst #(.SET_N(LOF_SET), .CLR_N(LOF_CLR), .RST_VAL(1'b1)) u_lof (
        .clk(clk), .rst(rst), .evt_vld(fas_vld), .evt_set(!fas_ok), .st_o(st_lof));

    always_comb begin
        alarm[IDX_LOS]     = st_los.act;
        alarm[IDX_LOF]     = st_lof.act;
        alarm[IDX_AIS]     = st_ais.act;
        alarm[IDX_RAI]     = st_rai.act;
        alarm_chg[IDX_LOS] = st_los.chg;
        alarm_chg[IDX_LOF] = st_lof.chg;
        alarm_chg[IDX_AIS] = st_ais.chg;
        alarm_chg[IDX_RAI] = st_rai.chg;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (alarm == 4'b0010 && alarm_chg == 4'b0000));
endmodule

// File: tb/e3_alarm_mon_tb.sv
module e3_alarm_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FBITS = 1536;

    logic clk = 1'b0, rst = 1'b1, mode_bip = 1'b1;
    logic bit_vld = 1'b0, bit_dat = 1'b0, sof = 1'b0, fas_vld = 1'b0, fas_ok = 1'b0;
    logic [3:0] alarm, alarm_chg;

    int  n_chk = 0, n_err = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    e3_alarm_mon u_dut (
        .clk(clk), .rst(rst), .mode_bip(mode_bip), .bit_vld(bit_vld), .bit_dat(bit_dat),
        .sof(sof), .fas_vld(fas_vld), .fas_ok(fas_ok), .alarm(alarm), .alarm_chg(alarm_chg));

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0b exp=%0b at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit [3:0] m_alm = 4'b0010, m_chg = 4'b0000;
    int zrun, wcnt, wrun, zc, pos, rs, rc, ls, lc;
    bit win_on, aseen, aph, pseen;

    always @(posedge clk) begin
        bit [3:0] old;
        if (rst) begin
            m_alm = 4'b0010; m_chg = 4'b0000;
            zrun = 0; wcnt = 0; wrun = 0; win_on = 0;
            zc = 0; aseen = 0; aph = 0; pos = 0; pseen = 0;
            rs = 0; rc = 0; ls = 0; lc = 0;
        end else begin
            old = m_alm;
            // loss of signal
            if (!mode_bip) begin
                m_alm[0] = 0; zrun = 0; win_on = 0; wcnt = 0; wrun = 0;
            end else if (bit_vld) begin
                if (!m_alm[0]) begin
                    zrun = bit_dat ? 0 : zrun + 1;
                    if (zrun >= 192) begin m_alm[0] = 1; win_on = 0; end
                end else if (!win_on) begin
                    if (bit_dat) begin win_on = 1; wcnt = 1; wrun = 0; end
                end else begin
                    wcnt++;
                    wrun = bit_dat ? 0 : wrun + 1;
                    if (wrun >= 4) win_on = 0;
                    else if (wcnt == 192) begin m_alm[0] = 0; win_on = 0; zrun = 0; end
                end
            end
            // alarm indication: pairs of frames
            if (sof) begin
                if (!aseen) begin aseen = 1; aph = 0; zc = 0; end
                else if (!aph) aph = 1;
                else begin m_alm[2] = (zc <= 4); aph = 0; zc = 0; end
            end else if (aseen && bit_vld && !bit_dat) zc++;
            // remote alarm: bit 11 of each frame
            if (sof) begin pseen = 1; pos = 0; end
            else if (pseen && bit_vld) begin
                pos++;
                if (pos == 11) begin
                    if (bit_dat) begin rs++; rc = 0; if (rs >= 4) m_alm[3] = 1; end
                    else begin rc++; rs = 0; if (rc >= 4) m_alm[3] = 0; end
                end
            end
            // loss of frame
            if (fas_vld) begin
                if (!fas_ok) begin ls++; lc = 0; if (ls >= 4) m_alm[1] = 1; end
                else begin lc++; ls = 0; if (lc >= 3) m_alm[1] = 0; end
            end
            m_chg = m_alm ^ old;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2/R3/R4 los", alarm[0], m_alm[0]);
            chk("R6 lof", alarm[1], m_alm[1]);
            chk("R5 ais", alarm[2], m_alm[2]);
            chk("R7 rai", alarm[3], m_alm[3]);
            for (int i = 0; i < 4; i++) chk("R8 chg", alarm_chg[i], m_chg[i]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic v, input logic d, input logic s, input logic fv, input logic fo);
        bit_vld = v; bit_dat = d; sof = s; fas_vld = fv; fas_ok = fo;
        @(negedge clk);
    endtask

    task automatic bits(input int n, input logic d);
        for (int i = 0; i < n; i++) cyc(1, d, 0, 0, 0);
    endtask

    // kind 0: ones with nz zeros from bit 100; kind 1: alternating, odd bits one
    task automatic send_frame(input int kind, input int nz, input logic b11, input logic fok);
        cyc(0, 0, 1, 0, 0);
        for (int p = 1; p <= FBITS; p++) begin
            logic d;
            if (p == 11)        d = b11;
            else if (kind == 1) d = (p % 2 == 1);
            else                d = !(p >= 100 && p < 100 + nz);
            cyc(1, d, 0, 0, 0);
        end
        cyc(0, 0, 0, 1, fok);
    endtask

    task automatic fas(input logic ok);
        cyc(0, 0, 0, 1, ok);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 alarm", alarm[0], 1'b0);
        chk("R1 alarm", alarm[1], 1'b1);
        chk("R1 alarm", alarm[2], 1'b0);
        chk("R1 alarm", alarm[3], 1'b0);
        chk("R1 chg", |alarm_chg, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", alarm[1], 1'b1);

        // frames 0..3: alternating data, good alignment
        send_frame(1, 0, 0, 1);
        send_frame(1, 0, 0, 1);
        chk("R6 lof held after 2 good", alarm[1], 1'b1);
        send_frame(1, 0, 0, 1);
        chk("R6 lof clear after 3 good", alarm[1], 1'b0);
        send_frame(1, 0, 0, 1);
        // frames 4..7: all ones with bit 11 set
        for (int f = 4; f <= 6; f++) send_frame(0, 0, 1, 1);
        chk("R7 rai not yet after 3", alarm[3], 1'b0);
        chk("R5 ais set, pair of zero-free frames", alarm[2], 1'b1);
        send_frame(0, 0, 1, 1);
        chk("R7 rai set after 4", alarm[3], 1'b1);
        // pair 8,9 holds exactly 4 zeros, pair 10,11 holds 5
        send_frame(0, 2, 1, 1);
        send_frame(0, 2, 1, 1);
        send_frame(0, 3, 1, 1);
        chk("R5 ais kept at 4 zeros", alarm[2], 1'b1);
        send_frame(0, 2, 1, 1);
        send_frame(0, 0, 0, 1);
        chk("R5 ais cleared at 5 zeros", alarm[2], 1'b0);
        // frames 13..19: remote alarm clear path
        send_frame(0, 0, 0, 1);
        send_frame(0, 0, 0, 1);
        send_frame(0, 0, 1, 1);
        chk("R7 rai kept, zero run broken", alarm[3], 1'b1);
        for (int f = 16; f <= 18; f++) send_frame(0, 0, 0, 1);
        chk("R7 rai kept after 3 zero frames", alarm[3], 1'b1);
        send_frame(0, 0, 0, 1);
        chk("R7 rai clear after 4 zero frames", alarm[3], 1'b0);

        // loss of frame counting
        repeat (3) fas(0);
        fas(1);
        chk("R6 lof clear, bad run broken", alarm[1], 1'b0);
        repeat (3) fas(0);
        chk("R6 lof clear after 3 bad", alarm[1], 1'b0);
        fas(0);
        chk("R6 lof set after 4 bad", alarm[1], 1'b1);
        chk("R8 lof chg pulse", alarm_chg[1], 1'b1);
        fas(1); fas(1); fas(0); fas(1); fas(1);
        chk("R6 lof held, good run broken", alarm[1], 1'b1);
        fas(1);
        chk("R6 lof clear after 3 good", alarm[1], 1'b0);

        // loss of signal declare
        bits(191, 0);
        chk("R2 los off at 191 zeros", alarm[0], 1'b0);
        cyc(0, 0, 0, 0, 0);
        bits(1, 0);
        chk("R2 los on at 192 zeros, idle gap ignored", alarm[0], 1'b1);
        chk("R8 los chg pulse", alarm_chg[0], 1'b1);
        cyc(0, 0, 0, 0, 0);
        chk("R8 los chg one cycle", alarm_chg[0], 1'b0);
        // clear window aborted by four zeros
        bits(50, 0);
        for (int i = 0; i < 151; i++) cyc(1, (i % 4 == 0), 0, 0, 0);
        bits(4, 0);
        bits(100, 1);
        chk("R3 los held, window restarted after zero run", alarm[0], 1'b1);
        bits(91, 1);
        chk("R3 los held at 191 window bits", alarm[0], 1'b1);
        bits(1, 1);
        chk("R3 los clear at 192 window bits", alarm[0], 1'b0);

        // unipolar mode
        bits(200, 0);
        chk("R2 los on again", alarm[0], 1'b1);
        mode_bip = 1'b0;
        cyc(0, 0, 0, 0, 0);
        chk("R4 los dropped in unipolar", alarm[0], 1'b0);
        chk("R8 los chg on mode drop", alarm_chg[0], 1'b1);
        bits(300, 0);
        chk("R4 los held off in unipolar", alarm[0], 1'b0);
        mode_bip = 1'b1;
        cyc(0, 0, 0, 0, 0);
        bits(191, 0);
        chk("R4 count restarted after bipolar", alarm[0], 1'b0);
        bits(1, 0);
        chk("R4 los on at fresh 192", alarm[0], 1'b1);
        repeat (3) cyc(0, 0, 0, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            $display("FAIL watchdog R1-path stalled act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end
endmodule